// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a system against stalled software. It watches a 64-bit free-running system count and compares it against an absolute deadline held in the block. Each time software restarts the watchdog, the deadline is set to the present count plus a programmable 48-bit period. If the count reaches the deadline, the first stage fires: the block raises an interrupt and sets a new deadline one period later. If software still does not respond and the count reaches that second deadline, the second stage fires and the block raises a reset request. The reset itself is carried out elsewhere.

Software uses two register windows, each accessed as 32-bit words. The restart window holds a single kick register that has no stored contents. The control window holds the enable, the period, the deadline and the stage flags. Both windows carry a read-only identification word. Reads return their data in the same cycle as the select. A write takes effect at the next clock edge.

Top module: `wdog_two_stage`

## Requirements
- R1: The period is 48 bits. The low word is at control offset 0x008. Bits 15:0 of a write to offset 0x00C form the upper 16 bits, and the other written bits are dropped. Both registers read back zero-extended, so a period with a nonzero upper part delays expiry beyond the low word alone.
- R2: A restart loads the deadline with sys_count plus the period when the enable that results from the restart is 1. While that enable is 0, a restart leaves the deadline unchanged. The deadline reads back as two words: bits 31:0 at control offset 0x010 and bits 63:32 at 0x014.
- R3: The first stage fires when the block is enabled, sys_count >= deadline (unsigned) and the first-stage flag is clear. At that edge the block sets the flag, the deadline is reloaded with sys_count plus the period, and irq_o is high from the next cycle.
- R4: The second stage fires when the block is enabled, sys_count reaches the deadline and the first-stage flag is already set. At that edge the block sets the second-stage flag, rst_req_o goes high and the deadline does not change. rst_req_o is never high while irq_o is low.
- R5: A write of any data to restart-window offset 0x000 clears both stage flags and restarts the timeout. This write takes priority over an expiry in the same cycle.
- R6: A write to control offset 0x000 stores only bit 0 as the enable, clears both stage flags and restarts the timeout. A write to either period register also clears both flags and restarts the timeout.
- R7: A write to a deadline word replaces only that half of the deadline and leaves both stage flags and the outputs unchanged.
- R8: A read of restart-window offset 0x000 returns 0 and has no side effect. Offset 0xFCC in either window returns the identification word (default 0x5A170B02). Every unmapped offset reads as 0.
- R9: Reset (synchronous, active low) clears the enable, both flags, the period and the deadline, so both outputs are low.
- R10: While the enable is 0, neither stage can fire, whatever sys_count is.
- R11: Expiry is edge-qualified. A single continuous stretch of sys_count >= deadline advances the block by at most one stage. A restart re-arms edge detection.
- R12: The control register at offset 0x000 reads bit 0 = enable, bit 1 = first-stage flag, bit 2 = second-stage flag, all other bits 0. Bits 1 and 2 are read-only. irq_o mirrors bit 1 and rst_req_o mirrors bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_sel | input | 1 | Restart window access strobe |
| rf_wr | input | 1 | Restart window write (1) or read (0) |
| rf_addr | input | 12 | Restart window byte offset |
| rf_rdata | output | 32 | Restart window read data |
| cf_sel | input | 1 | Control window access strobe |
| cf_wr | input | 1 | Control window write (1) or read (0) |
| cf_addr | input | 12 | Control window byte offset |
| cf_wdata | input | 32 | Control window write data |
| cf_rdata | output | 32 | Control window read data |
| sys_count | input | 64 | Free-running system count |
| irq_o | output | 1 | First-stage interrupt |
| rst_req_o | output | 1 | Second-stage reset request |

## Verification
A wrong first-stage flag appears at irq_o one cycle after the edge where the deadline was crossed. A wrong second-stage flag appears at rst_req_o in the same way. Either fault also shows in the control register read in the following cycle. A wrong deadline or period stays hidden until the deadline word is read back, or until expiry arrives early or late. For that reason, the deadline is read after every restart and after every first-stage reload. A broken edge qualifier shows up only when a zero period keeps the count past the deadline: rst_req_o would then rise one cycle after irq_o.

// File: rtl/wdog_pkg.sv
// Package: shared constants and types for the two-stage watchdog.
// Assumes 32-bit register words and 12-bit byte offsets inside each window.
package wdog_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    // Restart window offsets
    localparam logic [ADDR_W-1:0] RW_KICK  = 12'h000;
    // Control window offsets
    localparam logic [ADDR_W-1:0] CW_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] CW_PER_L = 12'h008;
    localparam logic [ADDR_W-1:0] CW_PER_H = 12'h00C;
    localparam logic [ADDR_W-1:0] CW_DL_L  = 12'h010;
    localparam logic [ADDR_W-1:0] CW_DL_H  = 12'h014;
    // Identification word, present in both windows
    localparam logic [ADDR_W-1:0] ANY_IDENT = 12'hFCC;

    // Write strobes decoded from both windows
    typedef struct packed {
        logic kick;
        logic ctrl;
        logic per_lo;
        logic per_hi;
        logic dl_lo;
        logic dl_hi;
    } wd_strobe_t;

endpackage

// File: rtl/wdog_decode.sv
// Module: write decoder for both register windows.
// Turns each accepted write into a one-cycle strobe and flags restart events.
// Assumes a write is accepted in any cycle where sel and wr are both high.
module wdog_decode
    import wdog_pkg::*;
(
    input  logic              rf_sel,
    input  logic              rf_wr,
    input  logic [ADDR_W-1:0] rf_addr,
    input  logic              cf_sel,
    input  logic              cf_wr,
    input  logic [ADDR_W-1:0] cf_addr,
    output wd_strobe_t        stb,
    output logic              restart
);

    logic rf_w;
    logic cf_w;

    // Qualify writes per window
    always_comb begin
        rf_w = rf_sel && rf_wr;
        cf_w = cf_sel && cf_wr;
    end

    // Decode write strobes by offset
    always_comb begin
        stb.kick   = rf_w && (rf_addr == RW_KICK);
        stb.ctrl   = cf_w && (cf_addr == CW_CTRL);
        stb.per_lo = cf_w && (cf_addr == CW_PER_L);
        stb.per_hi = cf_w && (cf_addr == CW_PER_H);
        stb.dl_lo  = cf_w && (cf_addr == CW_DL_L);
        stb.dl_hi  = cf_w && (cf_addr == CW_DL_H);
    end

    // Any write that restarts the timeout
    always_comb begin
        restart = stb.kick || stb.ctrl || stb.per_lo || stb.per_hi;
    end

endmodule

// File: rtl/wdog_expiry.sv
// Module: deadline comparator with edge qualification.
// Reports one expiry pulse per rising edge of (enabled && count >= deadline).
// Assumes the count input is already synchronous to clk.
module wdog_expiry #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] deadline,
    output logic             expire
);

    logic hit;
    logic hit_q;

    // Level condition: enabled and deadline reached (unsigned)
    always_comb begin
        hit = en && (count >= deadline);
    end

    // Remember the last level; a restart forgets it so a new period gets a fresh edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (restart) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit;
        end
    end

    // Rising edge of the level is an expiry
    always_comb begin
        expire = hit && !hit_q;
    end

endmodule

// File: rtl/wdog_state.sv
// Module: watchdog state registers: enable, period, deadline, stage flags.
// Restart writes take priority over expiry in the same cycle.
// Deadline-word writes never touch the stage flags.
// Assumes CNT_W = 2*WORD_W and WORD_W < OFS_W <= CNT_W.
module wdog_state
    import wdog_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int OFS_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wd_strobe_t        stb,
    input  logic              restart,
    input  logic              expire,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic              en,
    output logic              ws0,
    output logic              ws1,
    output logic [OFS_W-1:0]  period,
    output logic [CNT_W-1:0]  deadline
);

    localparam int HI_W  = OFS_W - WORD_W;
    localparam int PAD_W = CNT_W - OFS_W;

    logic [OFS_W-1:0] period_nx;
    logic             en_nx;
    logic [CNT_W-1:0] reload;

    // Period and enable as they will be after this cycle's writes
    always_comb begin
        period_nx = period;
        if (stb.per_lo) period_nx[WORD_W-1:0]     = wdata;
        if (stb.per_hi) period_nx[OFS_W-1:WORD_W] = wdata[HI_W-1:0];
        en_nx = stb.ctrl ? wdata[0] : en;
    end

    // New deadline: present count plus the updated period
    always_comb begin
        reload = count + {{PAD_W{1'b0}}, period_nx};
    end

    // Period and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            en     <= 1'b0;
        end else begin
            period <= period_nx;
            en     <= en_nx;
        end
    end

    // Stage flags and deadline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws0      <= 1'b0;
            ws1      <= 1'b0;
            deadline <= '0;
        end else if (restart) begin
            ws0 <= 1'b0;
            ws1 <= 1'b0;
            if (en_nx) deadline <= reload;
        end else begin
            if (expire) begin
                if (!ws0) begin
                    ws0      <= 1'b1;
                    deadline <= reload;
                end else begin
                    ws1 <= 1'b1;
                end
            end
            if (stb.dl_lo) deadline[WORD_W-1:0]     <= wdata;
            if (stb.dl_hi) deadline[CNT_W-1:WORD_W] <= wdata;
        end
    end

endmodule

// File: rtl/wdog_rdmux.sv
// Module: read-data multiplexers for both windows.
// Read data is combinational; it is zero when not selected, on writes, and at unmapped offsets.
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter int               CNT_W    = 64,
    parameter int               OFS_W    = 48,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h5A17_0B02
) (
    input  logic              rf_sel,
    input  logic              rf_wr,
    input  logic [ADDR_W-1:0] rf_addr,
    input  logic              cf_sel,
    input  logic              cf_wr,
    input  logic [ADDR_W-1:0] cf_addr,
    input  logic              en,
    input  logic              ws0,
    input  logic              ws1,
    input  logic [OFS_W-1:0]  period,
    input  logic [CNT_W-1:0]  deadline,
    output logic [WORD_W-1:0] rf_rdata,
    output logic [WORD_W-1:0] cf_rdata
);

    localparam int HI_W = OFS_W - WORD_W;

    // Restart window: the kick offset reads as zero, only the ident word has content
    always_comb begin
        rf_rdata = '0;
        if (rf_sel && !rf_wr && (rf_addr == ANY_IDENT)) rf_rdata = ID_VALUE;
    end

    // Control window register select
    always_comb begin
        cf_rdata = '0;
        if (cf_sel && !cf_wr) begin
            case (cf_addr)
                CW_CTRL:   cf_rdata = {{(WORD_W-3){1'b0}}, ws1, ws0, en};
                CW_PER_L:  cf_rdata = period[WORD_W-1:0];
                CW_PER_H:  cf_rdata = {{(WORD_W-HI_W){1'b0}}, period[OFS_W-1:WORD_W]};
                CW_DL_L:   cf_rdata = deadline[WORD_W-1:0];
                CW_DL_H:   cf_rdata = deadline[CNT_W-1:WORD_W];
                ANY_IDENT: cf_rdata = ID_VALUE;
                default:   cf_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_two_stage.sv
// Module: two-stage watchdog top level.
// The first expiry raises irq_o and re-arms the deadline. A second expiry raises rst_req_o.
// Assumes sys_count is synchronous to clk and that both windows use word accesses.
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int                CNT_W    = 64,
    parameter int                OFS_W    = 48,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h5A17_0B02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_sel,
    input  logic              rf_wr,
    input  logic [ADDR_W-1:0] rf_addr,
    output logic [WORD_W-1:0] rf_rdata,
    input  logic              cf_sel,
    input  logic              cf_wr,
    input  logic [ADDR_W-1:0] cf_addr,
    input  logic [WORD_W-1:0] cf_wdata,
    output logic [WORD_W-1:0] cf_rdata,
    input  logic [CNT_W-1:0]  sys_count,
    output logic              irq_o,
    output logic              rst_req_o
);

    wd_strobe_t       stb;
    logic             restart;
    logic             expire;
    logic             en_q;
    logic             ws0_q;
    logic             ws1_q;
    logic [OFS_W-1:0] period_q;
    logic [CNT_W-1:0] deadline_q;

    wdog_decode u_decode (
        .rf_sel  (rf_sel),
        .rf_wr   (rf_wr),
        .rf_addr (rf_addr),
        .cf_sel  (cf_sel),
        .cf_wr   (cf_wr),
        .cf_addr (cf_addr),
        .stb     (stb),
        .restart (restart)
    );

    wdog_expiry #(.CNT_W(CNT_W)) u_expiry (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .restart  (restart),
        .count    (sys_count),
        .deadline (deadline_q),
        .expire   (expire)
    );

    wdog_state #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb),
        .restart  (restart),
        .expire   (expire),
        .wdata    (cf_wdata),
        .count    (sys_count),
        .en       (en_q),
        .ws0      (ws0_q),
        .ws1      (ws1_q),
        .period   (period_q),
        .deadline (deadline_q)
    );

    wdog_rdmux #(.CNT_W(CNT_W), .OFS_W(OFS_W), .ID_VALUE(ID_VALUE)) u_rdmux (
        .rf_sel   (rf_sel),
        .rf_wr    (rf_wr),
        .rf_addr  (rf_addr),
        .cf_sel   (cf_sel),
        .cf_wr    (cf_wr),
        .cf_addr  (cf_addr),
        .en       (en_q),
        .ws0      (ws0_q),
        .ws1      (ws1_q),
        .period   (period_q),
        .deadline (deadline_q),
        .rf_rdata (rf_rdata),
        .cf_rdata (cf_rdata)
    );

    // Outputs follow the stage flags
    always_comb begin
        irq_o     = ws0_q;
        rst_req_o = ws1_q;
    end

endmodule

// File: rtl/wdog_two_stage_chk.sv
// Module: property checker for the two-stage watchdog, bound into the top level.
// Observes ports plus the enable register and the comparator's expiry pulse.
module wdog_two_stage_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rf_sel,
    input logic              rf_wr,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              cf_sel,
    input logic              cf_wr,
    input logic [ADDR_W-1:0] cf_addr,
    input logic [WORD_W-1:0] cf_wdata,
    input logic              en_q,
    input logic              expire,
    input logic              irq_o,
    input logic              rst_req_o
);

    logic kick_w;
    logic ctl_w;
    logic per_w;
    logic dl_w;

    // Recompute write classes from the ports
    always_comb begin
        kick_w = rf_sel && rf_wr && (rf_addr == 12'h000);
        ctl_w  = cf_sel && cf_wr && (cf_addr == 12'h000);
        per_w  = cf_sel && cf_wr && ((cf_addr == 12'h008) || (cf_addr == 12'h00C));
        dl_w   = cf_sel && cf_wr && ((cf_addr == 12'h010) || (cf_addr == 12'h014));
    end

    assert_irq_from_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire));

    assert_reset_needs_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> irq_o);

    assert_single_stage_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(irq_o));

    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_w |=> (!irq_o && !rst_req_o));

    assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w |=> (!irq_o && !rst_req_o && (en_q == $past(cf_wdata[0]))));

    assert_period_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_w |=> (!irq_o && !rst_req_o));

    assert_deadline_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_w && !kick_w && !expire) |=> ($stable(irq_o) && $stable(rst_req_o)));

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!$rose(irq_o) && !$rose(rst_req_o)));

endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_sel    (rf_sel),
    .rf_wr     (rf_wr),
    .rf_addr   (rf_addr),
    .cf_sel    (cf_sel),
    .cf_wr     (cf_wr),
    .cf_addr   (cf_addr),
    .cf_wdata  (cf_wdata),
    .en_q      (en_q),
    .expire    (expire),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/wdog_two_stage_tb.sv
// Testbench: a table of steps walked by one loop, then directed tests for reset and a restart collision.
// Each step drives the inputs at a negedge. A read is checked before the next posedge.
// irq_o and rst_req_o are checked 1 ns after the posedge.
module wdog_two_stage_tb;

    localparam logic [31:0] IDENT = 32'h5A17_0B02;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic        rfw;    // 1 = restart window, 0 = control window
        logic [11:0] addr;
        logic [31:0] data;
        logic [63:0] cnt;
        logic        irq;
        logic        rq;
        logic [31:0] rd;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 45;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_R, 1'b0, 12'h000, 32'h0,        64'd0,    1'b0, 1'b0, 32'd0,    4'd9 },  // R9 ctrl after reset
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd0,    1'b0, 1'b0, 32'd0,    4'd9 },  // R9 deadline after reset
        '{OP_W, 1'b0, 12'h008, 32'd100,      64'd10,   1'b0, 1'b0, 32'd0,    4'd1 },  // R1 period low
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd11,   1'b0, 1'b0, 32'd0,    4'd2 },  // R2 disabled: no load
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd500,  1'b0, 1'b0, 32'd0,    4'd10},  // R10
        '{OP_W, 1'b0, 12'h000, 32'hFFFFFFFF, 64'd1000, 1'b0, 1'b0, 32'd0,    4'd6 },  // R6 enable
        '{OP_R, 1'b0, 12'h000, 32'h0,        64'd1001, 1'b0, 1'b0, 32'd1,    4'd6 },  // R6 only bit 0 kept
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd1002, 1'b0, 1'b0, 32'd1100, 4'd2 },  // R2
        '{OP_R, 1'b0, 12'h014, 32'h0,        64'd1003, 1'b0, 1'b0, 32'd0,    4'd2 },  // R2
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd1099, 1'b0, 1'b0, 32'd0,    4'd3 },  // R3 not yet
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd1100, 1'b1, 1'b0, 32'd0,    4'd3 },  // R3 first stage
        '{OP_R, 1'b0, 12'h000, 32'h0,        64'd1101, 1'b1, 1'b0, 32'd3,    4'd12},  // R12
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd1102, 1'b1, 1'b0, 32'd1200, 4'd3 },  // R3 reload
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd1199, 1'b1, 1'b0, 32'd0,    4'd4 },  // R4 not yet
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd1200, 1'b1, 1'b1, 32'd0,    4'd4 },  // R4 second stage
        '{OP_R, 1'b0, 12'h000, 32'h0,        64'd1201, 1'b1, 1'b1, 32'd7,    4'd12},  // R12
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd1300, 1'b1, 1'b1, 32'd1200, 4'd4 },  // R4 deadline unchanged
        '{OP_W, 1'b1, 12'h000, 32'hDEADBEEF, 64'd2000, 1'b0, 1'b0, 32'd0,    4'd5 },  // R5 kick
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd2001, 1'b0, 1'b0, 32'd2100, 4'd5 },  // R5 restart
        '{OP_R, 1'b1, 12'h000, 32'h0,        64'd2002, 1'b0, 1'b0, 32'd0,    4'd8 },  // R8 kick reads 0
        '{OP_R, 1'b1, 12'hFCC, 32'h0,        64'd2002, 1'b0, 1'b0, IDENT,    4'd8 },  // R8
        '{OP_R, 1'b0, 12'hFCC, 32'h0,        64'd2002, 1'b0, 1'b0, IDENT,    4'd8 },  // R8
        '{OP_R, 1'b0, 12'h004, 32'h0,        64'd2002, 1'b0, 1'b0, 32'd0,    4'd8 },  // R8 unmapped
        '{OP_W, 1'b0, 12'h00C, 32'hABCD0001, 64'd2002, 1'b0, 1'b0, 32'd0,    4'd1 },  // R1 period high
        '{OP_R, 1'b0, 12'h00C, 32'h0,        64'd2002, 1'b0, 1'b0, 32'd1,    4'd1 },  // R1 masked
        '{OP_R, 1'b0, 12'h008, 32'h0,        64'd2002, 1'b0, 1'b0, 32'd100,  4'd1 },  // R1
        '{OP_R, 1'b0, 12'h014, 32'h0,        64'd2002, 1'b0, 1'b0, 32'd1,    4'd1 },  // R1 48-bit sum
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd2002, 1'b0, 1'b0, 32'd2102, 4'd1 },  // R1
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd2102, 1'b0, 1'b0, 32'd0,    4'd1 },  // R1 no early expiry
        '{OP_W, 1'b0, 12'h014, 32'd0,        64'd2103, 1'b0, 1'b0, 32'd0,    4'd7 },  // R7 deadline high
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd2104, 1'b1, 1'b0, 32'd0,    4'd7 },  // R7 new deadline acts
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd2105, 1'b1, 1'b0, 32'd2204, 4'd3 },  // R3 reload
        '{OP_W, 1'b0, 12'h010, 32'd5000,     64'd2106, 1'b1, 1'b0, 32'd0,    4'd7 },  // R7 flags kept
        '{OP_R, 1'b0, 12'h010, 32'h0,        64'd2107, 1'b1, 1'b0, 32'd5000, 4'd7 },  // R7
        '{OP_R, 1'b0, 12'h000, 32'h0,        64'd2107, 1'b1, 1'b0, 32'd3,    4'd7 },  // R7
        '{OP_W, 1'b0, 12'h000, 32'd0,        64'd2108, 1'b0, 1'b0, 32'd0,    4'd6 },  // R6 disable clears
        '{OP_W, 1'b0, 12'h014, 32'd0,        64'd2109, 1'b0, 1'b0, 32'd0,    4'd7 },  // R7
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd9000, 1'b0, 1'b0, 32'd0,    4'd10},  // R10 past deadline
        '{OP_R, 1'b0, 12'h000, 32'h0,        64'd9001, 1'b0, 1'b0, 32'd0,    4'd10},  // R10
        '{OP_W, 1'b0, 12'h00C, 32'd0,        64'd9002, 1'b0, 1'b0, 32'd0,    4'd6 },  // R6
        '{OP_W, 1'b0, 12'h008, 32'd0,        64'd9003, 1'b0, 1'b0, 32'd0,    4'd6 },  // R6
        '{OP_W, 1'b0, 12'h000, 32'd1,        64'd9004, 1'b0, 1'b0, 32'd0,    4'd11},  // R11 zero period
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd9005, 1'b1, 1'b0, 32'd0,    4'd11},  // R11 one stage
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd9006, 1'b1, 1'b0, 32'd0,    4'd11},  // R11 no second
        '{OP_I, 1'b0, 12'h000, 32'h0,        64'd9010, 1'b1, 1'b0, 32'd0,    4'd11}   // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_sel = 1'b0, rf_wr = 1'b0;
    logic [11:0] rf_addr = '0;
    logic [31:0] rf_rdata;
    logic        cf_sel = 1'b0, cf_wr = 1'b0;
    logic [11:0] cf_addr = '0;
    logic [31:0] cf_wdata = '0;
    logic [31:0] cf_rdata;
    logic [63:0] sys_count = '0;
    logic        irq_o, rst_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdog_two_stage u_dut (
        .clk(clk), .rst_n(rst_n),
        .rf_sel(rf_sel), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .cf_sel(cf_sel), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
        .cf_rdata(cf_rdata), .sys_count(sys_count), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check read data before the edge, outputs after it
    task automatic do_step(input step_t s);
        @(negedge clk);
        sys_count = s.cnt;
        rf_sel = (s.op != OP_I) && s.rfw;
        cf_sel = (s.op != OP_I) && !s.rfw;
        rf_wr = (s.op == OP_W);
        cf_wr = (s.op == OP_W);
        rf_addr = s.addr;
        cf_addr = s.addr;
        cf_wdata = s.data;
        #1;
        if (s.op == OP_R)
            check($sformatf("R%0d rdata @%0h", s.req, s.addr), s.rfw ? rf_rdata : cf_rdata, s.rd);
        @(posedge clk);
        #1;
        rf_sel = 1'b0;
        cf_sel = 1'b0;
        check($sformatf("R%0d irq_o", s.req), irq_o, s.irq);
        check($sformatf("R%0d rst_req_o", s.req), rst_req_o, s.rq);
    endtask

    function automatic step_t mk(input logic [1:0] op, input logic rfw, input logic [11:0] a,
                                 input logic [31:0] d, input logic [63:0] c, input logic i,
                                 input logic r, input logic [31:0] rd, input logic [3:0] q);
        step_t s;
        s = '{op, rfw, a, d, c, i, r, rd, q};
        return s;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 irq_o in reset", irq_o, 1'b0);
        check("R9 rst_req_o in reset", rst_req_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) do_step(STEPS[i]);

        // R9: reset while both stages are active clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 irq_o after reset", irq_o, 1'b0);
        check("R9 rst_req_o after reset", rst_req_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        do_step(mk(OP_R, 1'b0, 12'h000, 0, 64'd0, 1'b0, 1'b0, 32'd0, 4'd9));
        do_step(mk(OP_R, 1'b0, 12'h008, 0, 64'd0, 1'b0, 1'b0, 32'd0, 4'd9));
        do_step(mk(OP_R, 1'b0, 12'h010, 0, 64'd0, 1'b0, 1'b0, 32'd0, 4'd9));

        // R5: a kick in the same cycle as a deadline crossing wins
        do_step(mk(OP_W, 1'b0, 12'h008, 32'd50, 64'd0, 1'b0, 1'b0, 32'd0, 4'd5));
        do_step(mk(OP_W, 1'b0, 12'h000, 32'd1,  64'd0, 1'b0, 1'b0, 32'd0, 4'd5));
        do_step(mk(OP_W, 1'b1, 12'h000, 32'd0,  64'd60, 1'b0, 1'b0, 32'd0, 4'd5));
        do_step(mk(OP_I, 1'b0, 12'h000, 32'd0,  64'd61, 1'b0, 1'b0, 32'd0, 4'd5));
        do_step(mk(OP_R, 1'b0, 12'h010, 32'd0,  64'd62, 1'b0, 1'b0, 32'd110, 4'd5));
        do_step(mk(OP_I, 1'b0, 12'h000, 32'd0,  64'd110, 1'b1, 1'b0, 32'd0, 4'd3));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule